// File: doc/BRIEF.md
# Signed Arithmetic Unit with Selectable Overflow Handling

This block performs one 16-bit two's-complement operation at a time (add, subtract, multiply or divide) on two operands and writes a 16-bit destination word. Alongside the destination it keeps four status flags: carry, overflow, zero and sign. It also keeps a sticky overflow trap that records that some overflow has happened since software last cleared it. A 32-bit math register holds the full signed product of a multiply or the full signed quotient of a divide, so that a wide value stays available after the 16-bit destination has been clamped or cut.

A mode input chooses how an out-of-range result is written. With saturation (the default, mode low), the destination is pinned to the largest or smallest 16-bit value. With wrap (mode high), it takes the low 16 bits of the true result. A second control lets an operation run without touching the flags or the trap. Add and subtract finish in one cycle. Multiply and divide run on shared-nothing iterative engines that take one cycle per operand bit. The request side is a valid/ready pair: a request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a multiply or divide is in progress, and `in_valid` is ignored while `in_ready` is low. A taken request cannot be withdrawn. The result side has no back-pressure: `done` pulses for one cycle when the destination, flags and math register hold the new values, and those values then hold until the next completion.

Top module: `ovf_alu`

## Requirements
- R1: Opcode encoding on `in_op` is 0 add, 1 subtract (`in_a - in_b`), 2 multiply, 3 divide. An in-range add or subtract writes the exact result to `res`, and `done` is high in the cycle right after the request is taken.
- R2: `flg_carry` is set by an add whose unsigned 16-bit sum carries out of bit 15, and by a subtract with unsigned `in_a < in_b` (borrow). It is cleared by every other add or subtract and by every multiply or divide.
- R3: With `wrap_mode` low, a result outside -32768..32767 writes 16'h7FFF if the true result is positive and 16'h8000 if it is negative.
- R4: With `wrap_mode` high, a result outside the range writes the low 16 bits of the true result.
- R5: `flg_ovf` is set when the true result does not fit in 16 signed bits, or on divide by zero. It is cleared otherwise.
- R6: `flg_zero` is set when the written `res` is zero. `flg_sign` is set when bit 15 of the written `res` is one.
- R7: `ovf_trap` is set by any completed overflowing operation, stays set through later operations without overflow, and is cleared only by `trap_clr`. When a set and a clear fall on the same edge, the set wins.
- R8: A multiply writes the full 32-bit signed product to `math_reg`. A divide writes the quotient, truncated toward zero and sign-extended to 32 bits. Add and subtract leave `math_reg` unchanged.
- R9: Divide by zero is an overflow and finishes in the cycle right after the request. With saturation it writes 16'h7FFF for a non-negative dividend and 16'h8000 for a negative one. With wrap it writes 16'hFFFF. `math_reg` receives `res` sign-extended.
- R10: With `flag_hold` high when a request is taken, that operation still updates `res` and `math_reg`, but leaves all four flags and `ovf_trap` unchanged.
- R11: From a taken multiply (or divide by a non-zero value) until its completion, `busy` is high, `in_ready` is low, and a request presented then is dropped. `done` rises at most 18 cycles after the request and lasts one cycle.
- R12: After reset, `res`, `math_reg`, all flags, `ovf_trap`, `done` and `busy` are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 2 | Operation code |
| in_a | input | 16 | First operand, signed |
| in_b | input | 16 | Second operand (divisor), signed |
| wrap_mode | input | 1 | 0 saturate, 1 wrap on overflow; sampled with the request |
| flag_hold | input | 1 | Suppress flag and trap update for this request |
| trap_clr | input | 1 | Clear the sticky overflow trap |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | Multiply or divide in progress |
| res | output | 16 | Destination word |
| flg_carry | output | 1 | Carry or borrow flag |
| flg_ovf | output | 1 | Overflow flag |
| flg_zero | output | 1 | Zero flag |
| flg_sign | output | 1 | Sign flag |
| ovf_trap | output | 1 | Sticky overflow trap |
| math_reg | output | 32 | Wide result of last multiply or divide |

## Verification
The bench builds the unit with its default 16-bit width. At this width the clamp values 32767 and -32768 can be reached exactly. So can the one divide that overflows without a zero divisor (-32768 by -1), and products whose magnitude needs the full upper word of the math register. At this width the iterative engines also run 16 steps, which places the completion bound of the handshake within a short wait.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } alu_op_e;
endpackage

// File: rtl/ovf_alu_mul.sv
module ovf_alu_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int MW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [MW-1:0] acc, mcand;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic          run;

  // one shift-and-add step per cycle over unsigned magnitudes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        acc    <= '0;
        mcand  <= {{W{1'b0}}, mag_a};
        mplier <= mag_b;
        cnt    <= '0;
        run    <= 1'b1;
      end else if (run) begin
        acc    <= acc + (mplier[0] ? mcand : '0);
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/ovf_alu_div.sv
module ovf_alu_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mag_n,
  input  logic [W-1:0] mag_d,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  q, dvs;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic          fits;

  // restoring step: bring down one dividend bit, subtract when possible
  assign shifted = {rem[W-1:0], q[W-1]};
  assign fits    = shifted >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      q   <= '0;
      dvs <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem <= '0;
        q   <= mag_n;
        dvs <= mag_d;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? (shifted - {1'b0, dvs}) : shifted;
        q   <= {q[W-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quot = q;
endmodule

// File: rtl/ovf_alu_pack.sv
module ovf_alu_pack #(
  parameter int W = 16
) (
  input  logic signed [2*W:0] full,
  input  logic                dz,
  input  logic                dz_neg,
  input  logic                wrap,
  output logic [W-1:0]        dest,
  output logic                ovf
);
  localparam int FW = 2 * W + 1;
  localparam logic signed [FW-1:0] MAXV = {{(FW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [FW-1:0] MINV = {{(FW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic         in_range;
  logic         neg_true;
  logic [W-1:0] sat;

  assign in_range = (full <= MAXV) && (full >= MINV);
  assign ovf      = !in_range || dz;
  assign neg_true = dz ? dz_neg : full[FW-1];
  assign sat      = neg_true ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!ovf)      dest = full[W-1:0];
    else if (wrap) dest = dz ? '1 : full[W-1:0];
    else           dest = sat;
  end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_op,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic                wrap_mode,
  input  logic                flag_hold,
  input  logic                trap_clr,
  output logic                done,
  output logic                busy,
  output logic [DATA_W-1:0]   res,
  output logic                flg_carry,
  output logic                flg_ovf,
  output logic                flg_zero,
  output logic                flg_sign,
  output logic                ovf_trap,
  output logic [2*DATA_W-1:0] math_reg
);
  localparam int W  = DATA_W;
  localparam int MW = 2 * W;
  localparam int FW = 2 * W + 1;

  alu_op_e op_in, op_q;
  logic    acc_fire;
  logic    neg_q, wrap_q, hold_q;

  assign in_ready = !busy;
  assign acc_fire = in_valid && in_ready;
  assign op_in    = alu_op_e'(in_op);

  // single-cycle add/subtract path
  logic signed [FW-1:0] sa, sb, full_as;
  logic [W:0]           usum;
  logic                 cy_in;

  assign sa      = {{(FW-W){in_a[W-1]}}, in_a};
  assign sb      = {{(FW-W){in_b[W-1]}}, in_b};
  assign full_as = (op_in == OP_SUB) ? (sa - sb) : (sa + sb);
  assign usum    = {1'b0, in_a} + {1'b0, in_b};

  always_comb begin
    case (op_in)
      OP_ADD:  cy_in = usum[W];
      OP_SUB:  cy_in = in_a < in_b;
      default: cy_in = 1'b0;
    endcase
  end

  // operand magnitudes for the iterative engines
  logic [W-1:0] mag_a, mag_b;
  logic         div_zero, go_mul, go_div;

  assign mag_a    = in_a[W-1] ? (~in_a + 1'b1) : in_a;
  assign mag_b    = in_b[W-1] ? (~in_b + 1'b1) : in_b;
  assign div_zero = acc_fire && (op_in == OP_DIV) && (in_b == '0);
  assign go_mul   = acc_fire && (op_in == OP_MUL);
  assign go_div   = acc_fire && (op_in == OP_DIV) && (in_b != '0);

  logic          mul_fin, div_fin, eng_fin;
  logic [MW-1:0] mul_prod;
  logic [W-1:0]  div_quot;

  ovf_alu_mul #(.W(W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_mul),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .fin   (mul_fin),
    .prod  (mul_prod)
  );

  ovf_alu_div #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_div),
    .mag_n (mag_a),
    .mag_d (mag_b),
    .fin   (div_fin),
    .quot  (div_quot)
  );

  assign eng_fin = mul_fin || div_fin;

  // re-apply the sign to the engine magnitude
  logic signed [FW-1:0] mag_md, full_md;

  assign mag_md  = (op_q == OP_MUL) ? {1'b0, mul_prod} : {{(FW-W){1'b0}}, div_quot};
  assign full_md = neg_q ? -mag_md : mag_md;

  // overflow handling shared by both paths
  logic signed [FW-1:0] pk_full;
  logic                 pk_wrap, pk_ovf;
  logic [W-1:0]         pk_dest;

  assign pk_full = eng_fin ? full_md : full_as;
  assign pk_wrap = eng_fin ? wrap_q : wrap_mode;

  ovf_alu_pack #(.W(W)) u_pack (
    .full   (pk_full),
    .dz     (div_zero),
    .dz_neg (in_a[W-1]),
    .wrap   (pk_wrap),
    .dest   (pk_dest),
    .ovf    (pk_ovf)
  );

  logic wr, hold_sel, cy_sel;

  assign wr       = eng_fin || (acc_fire && ((op_in == OP_ADD) || (op_in == OP_SUB) || div_zero));
  assign hold_sel = eng_fin ? hold_q : flag_hold;
  assign cy_sel   = eng_fin ? 1'b0 : cy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_ADD;
      neg_q     <= 1'b0;
      wrap_q    <= 1'b0;
      hold_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      res       <= '0;
      math_reg  <= '0;
      flg_carry <= 1'b0;
      flg_ovf   <= 1'b0;
      flg_zero  <= 1'b0;
      flg_sign  <= 1'b0;
      ovf_trap  <= 1'b0;
    end else begin
      done <= wr;
      if (acc_fire) begin
        op_q   <= op_in;
        neg_q  <= in_a[W-1] ^ in_b[W-1];
        wrap_q <= wrap_mode;
        hold_q <= flag_hold;
      end
      if (go_mul || go_div) busy <= 1'b1;
      else if (eng_fin)     busy <= 1'b0;
      if (wr) res <= pk_dest;
      if (eng_fin)       math_reg <= full_md[MW-1:0];
      else if (div_zero) math_reg <= {{W{pk_dest[W-1]}}, pk_dest};
      if (wr && !hold_sel) begin
        flg_carry <= cy_sel;
        flg_ovf   <= pk_ovf;
        flg_zero  <= (pk_dest == '0);
        flg_sign  <= pk_dest[W-1];
      end
      if (wr && !hold_sel && pk_ovf) ovf_trap <= 1'b1;
      else if (trap_clr)             ovf_trap <= 1'b0;
    end
  end
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         done,
  input logic         busy,
  input logic [W-1:0] res,
  input logic         flg_carry,
  input logic         flg_ovf,
  input logic         flg_zero,
  input logic         flg_sign,
  input logic         ovf_trap,
  input logic         trap_clr,
  input logic         hold_q,
  input logic         wrap_q
);
  localparam int BW = $clog2(W + 4) + 1;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R11
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BW'(W + 2));

  // R7
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap && !trap_clr |=> ovf_trap);

  // R7
  trap_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hold_q && flg_ovf |-> ovf_trap);

  // R3
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hold_q && flg_ovf && !wrap_q |-> (res == {1'b0, {(W-1){1'b1}}}) || (res == {1'b1, {(W-1){1'b0}}}));

  // R6
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hold_q |-> (flg_zero == (res == '0)) && (flg_sign == res[W-1]));

  // R10
  flags_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({flg_carry, flg_ovf, flg_zero, flg_sign}));
endmodule

bind ovf_alu ovf_alu_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .busy      (busy),
  .res       (res),
  .flg_carry (flg_carry),
  .flg_ovf   (flg_ovf),
  .flg_zero  (flg_zero),
  .flg_sign  (flg_sign),
  .ovf_trap  (ovf_trap),
  .trap_clr  (trap_clr),
  .hold_q    (hold_q),
  .wrap_q    (wrap_q)
);

// File: tb/ovf_alu_tb.sv
module ovf_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 23;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        wrap_mode = 1'b0, flag_hold = 1'b0, trap_clr = 1'b0;
  logic        done, busy;
  logic [15:0] res;
  logic        flg_carry, flg_ovf, flg_zero, flg_sign, ovf_trap;
  logic [31:0] math_reg;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_alu #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .wrap_mode(wrap_mode),
    .flag_hold(flag_hold), .trap_clr(trap_clr), .done(done), .busy(busy),
    .res(res), .flg_carry(flg_carry), .flg_ovf(flg_ovf), .flg_zero(flg_zero),
    .flg_sign(flg_sign), .ovf_trap(ovf_trap), .math_reg(math_reg)
  );

  // {op, a, b, wrap, exp_res, exp_c, exp_v, chk_math, exp_math}
  localparam logic [85:0] VEC [NV] = '{
    {2'd0, 16'h0064, 16'h00C8, 1'b0, 16'h012C, 1'b0, 1'b0, 1'b0, 32'h0},
    {2'd0, 16'h7FFF, 16'h0001, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b0, 32'h0},
    {2'd0, 16'h7FFF, 16'h0001, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b0, 32'h0},
    {2'd0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 32'h0},
    {2'd0, 16'h8000, 16'hFFFF, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b0, 32'h0},
    {2'd0, 16'h8000, 16'hFFFF, 1'b1, 16'h7FFF, 1'b1, 1'b1, 1'b0, 32'h0},
    {2'd1, 16'h0005, 16'h0007, 1'b0, 16'hFFFE, 1'b1, 1'b0, 1'b0, 32'h0},
    {2'd1, 16'h8000, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0, 32'h0},
    {2'd1, 16'h0001, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h0},
    {2'd2, 16'h012C, 16'hFFFB, 1'b0, 16'hFA24, 1'b0, 1'b0, 1'b1, 32'hFFFFFA24},
    {2'd2, 16'h012C, 16'h012C, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b1, 32'h00015F90},
    {2'd2, 16'h012C, 16'h012C, 1'b1, 16'h5F90, 1'b0, 1'b1, 1'b1, 32'h00015F90},
    {2'd2, 16'hFED4, 16'h012C, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b1, 32'hFFFEA070},
    {2'd2, 16'hFED4, 16'h012C, 1'b1, 16'hA070, 1'b0, 1'b1, 1'b1, 32'hFFFEA070},
    {2'd3, 16'h0064, 16'hFFF9, 1'b0, 16'hFFF2, 1'b0, 1'b0, 1'b1, 32'hFFFFFFF2},
    {2'd3, 16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b1, 32'h00008000},
    {2'd3, 16'h8000, 16'hFFFF, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b1, 32'h00008000},
    {2'd3, 16'h0005, 16'h0000, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b1, 32'h00007FFF},
    {2'd3, 16'hFFF6, 16'h0000, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b1, 32'hFFFF8000},
    {2'd3, 16'hFFF6, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF},
    {2'd3, 16'hFFF9, 16'h0002, 1'b0, 16'hFFFD, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFD},
    {2'd2, 16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b1, 32'h00008000},
    {2'd2, 16'h0000, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // present one request, wait for done; returns cycles from request to done
  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic wr, input logic hold, output int lat);
    in_op = op; in_a = a; in_b = b; wrap_mode = wr; flag_hold = hold;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk("R11 done timeout", 32'd0, 32'd1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    int lat;
    logic exp_trap;
    logic [31:0] m_keep;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 res", {16'h0, res}, 32'h0);
    chk("R12 math", math_reg, 32'h0);
    chk("R12 flags", {28'h0, flg_carry, flg_ovf, flg_zero, flg_sign}, 32'h0);
    chk("R12 trap/done/busy", {29'h0, ovf_trap, done, busy}, 32'h0);
    chk("R12 ready", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    exp_trap = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      v = VEC[i];
      run_op(v[85:84], v[83:68], v[67:52], v[51], 1'b0, lat);
      exp_trap = exp_trap | v[33];
      chk($sformatf("R1/R3/R4/R9 res vec %0d", i), {16'h0, res}, {16'h0, v[50:35]});
      chk($sformatf("R2 carry vec %0d", i), {31'h0, flg_carry}, {31'h0, v[34]});
      chk($sformatf("R5 ovf vec %0d", i), {31'h0, flg_ovf}, {31'h0, v[33]});
      chk($sformatf("R6 zero vec %0d", i), {31'h0, flg_zero}, {31'h0, v[50:35] == 16'h0});
      chk($sformatf("R6 sign vec %0d", i), {31'h0, flg_sign}, {31'h0, v[50]});
      chk($sformatf("R7 trap vec %0d", i), {31'h0, ovf_trap}, {31'h0, exp_trap});
      if (v[32]) chk($sformatf("R8 math vec %0d", i), math_reg, v[31:0]);
      if (v[85:84] < 2'd2 || v[67:52] == 16'h0)
        chk($sformatf("R1/R9 latency vec %0d", i), lat, 1);
      @(negedge clk);
    end

    // R7 clear, then a clean op keeps it clear
    trap_clr = 1'b1;
    @(negedge clk);
    trap_clr = 1'b0;
    chk("R7 trap cleared", {31'h0, ovf_trap}, 32'h0);
    run_op(2'd0, 16'h0002, 16'h0003, 1'b0, 1'b0, lat);
    chk("R7 trap stays clear", {31'h0, ovf_trap}, 32'h0);
    // R7 overflow then clean op: trap sticks
    run_op(2'd0, 16'h7000, 16'h7000, 1'b0, 1'b0, lat);
    run_op(2'd0, 16'h0001, 16'h0001, 1'b0, 1'b0, lat);
    chk("R7 trap sticky", {31'h0, ovf_trap}, 32'h1);
    chk("R5 ovf cleared", {31'h0, flg_ovf}, 32'h0);
    // R7 set wins over simultaneous clear
    trap_clr = 1'b1;
    @(negedge clk);
    trap_clr = 1'b0;
    trap_clr = 1'b1;
    run_op(2'd1, 16'h8000, 16'h0001, 1'b0, 1'b0, lat);
    trap_clr = 1'b0;
    chk("R7 set beats clear", {31'h0, ovf_trap}, 32'h1);
    trap_clr = 1'b1;
    @(negedge clk);
    trap_clr = 1'b0;

    // R10 flag hold
    run_op(2'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, lat);
    run_op(2'd0, 16'h7FFF, 16'h0005, 1'b0, 1'b1, lat);
    chk("R10 res updates", {16'h0, res}, 32'h00007FFF);
    chk("R10 flags held", {28'h0, flg_carry, flg_ovf, flg_zero, flg_sign}, 32'h0000000A);
    chk("R10 trap held", {31'h0, ovf_trap}, 32'h0);
    run_op(2'd2, 16'h0007, 16'h0006, 1'b0, 1'b1, lat);
    chk("R10 math updates", math_reg, 32'd42);
    chk("R10 flags held mul", {28'h0, flg_carry, flg_ovf, flg_zero, flg_sign}, 32'h0000000A);

    // R11 handshake and dropped request
    in_op = 2'd2; in_a = 16'h0003; in_b = 16'h0004; wrap_mode = 1'b0; flag_hold = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R11 busy", {31'h0, busy}, 32'h1);
    chk("R11 not ready", {31'h0, in_ready}, 32'h0);
    in_op = 2'd0; in_a = 16'h0100; in_b = 16'h0100;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 2;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 latency bound", {31'h0, (lat <= 18)}, 32'h1);
    chk("R11 mul result", {16'h0, res}, 32'd12);
    m_keep = math_reg;
    @(negedge clk);
    chk("R11 done pulse", {31'h0, done}, 32'h0);
    chk("R11 dropped request", {16'h0, res}, 32'd12);
    // R8 add leaves math register
    run_op(2'd0, 16'h0001, 16'h0001, 1'b0, 1'b0, lat);
    chk("R8 add keeps math", math_reg, m_keep);
    chk("R1 add after mul", {16'h0, res}, 32'd2);

    finish_run();
  end
endmodule